// File: doc/BRIEF.md
# Synchronous Burst Read Controller

This block is the device-side read path of a synchronous burst memory. A host pulls chip select low, pulses the address strobe low to load a start address on a qualified clock edge, and after a programmed number of clock edges the block begins presenting words from its internal storage. Words come out as wrapped bursts of 4, 8 or 16 words, or as an unbounded linear stream. A ready/stall indicator (active-high WAIT) tells the host when the data bus carries a valid word.

The host can freeze an access at any point, during the initial latency or after words have started, by stopping the qualified clock and raising the output strobe. The controller then keeps its latency count, its word position and its captured address, and resumes from exactly that point once edges resume. The WAIT driver follows chip select alone, so it stays driven while the data bus is released. Two further modes repeat one word: a plain single-word mode, and a register-style mode that also raises WAIT once a burst's worth of words has been shown.

Top module: `sburst_rd_ctrl`

## Requirements
- R1: After reset, and whenever `ce_n` is high, `dq_oe`, `wait_oe` and `wait_o` are 0 and no access is active; raising `ce_n` ends any access.
- R2: An address is captured on a rising `clk` edge where `clk_en`=1, `ce_n`=0 and `lat_n`=0; the word stored at address `a` is `{~a, a}` (upper byte the inverse of the address, lower byte the address).
- R3: After a capture edge, `wait_o` stays 1 and `dq_o` stays 0 until the L-th following qualified edge, after which the first word is presented; L is `lat_cfg` for values 2 to 7, and values 0 and 1 act as 2.
- R4: With `blen_cfg` 0, 1 or 2 (4, 8 or 16 words) in mode 0, successive qualified edges step the address by one and wrap within the aligned block of that length, repeating indefinitely.
- R5: With `blen_cfg`=3 in mode 0 the address increases linearly by one per qualified edge and rolls over modulo 2^AW.
- R6: An edge with `clk_en`=0 changes no state: latency position, word position and outputs other than the enables are frozen, and the access resumes at the exact word or latency step, any number of times.
- R7: With `ce_n`=0, `dq_oe` is 1 only while `oe_n`=0, while `wait_oe` stays 1 regardless of `oe_n`.
- R8: In mode 1 (`mode_cfg`=1) the captured address's word is presented on every data cycle until the access ends.
- R9: In mode 2 the captured address's word is presented for exactly 4, 8 or 16 data cycles (per `blen_cfg`), after which `wait_o` returns to 1 and data stays invalid until a new capture; with `blen_cfg`=3 it never ends.
- R10: Whenever `wait_o` is 1, `dq_o` is all zeros; mode 3 behaves as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Qualifies a clock edge; 0 models a halted burst clock |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output strobe, active low |
| lat_n | input | 1 | Address strobe, active low |
| addr_i | input | AW | Start address |
| lat_cfg | input | LATW | Initial latency in qualified edges |
| blen_cfg | input | 2 | 0:4, 1:8, 2:16 words, 3:continuous |
| mode_cfg | input | 2 | 0 burst, 1 single word, 2 register-style, 3 as 0 |
| dq_o | output | DW | Read data, zero when not valid |
| dq_oe | output | 1 | Data bus drive enable |
| wait_o | output | 1 | Active-high stall, 1 when no valid word |
| wait_oe | output | 1 | WAIT drive enable |

## Verification
Bursts are started at addresses near an aligned boundary so wrapped and linear stepping give different word orders, and at the top of the address space to expose roll-over. The latency is swept over its extremes and the clamped values, which separates an off-by-one in the counter from a clamp fault. Suspends are placed inside the latency and at mid-burst words, repeated within one access, with the output strobe raised so that a frozen WAIT driver is told apart from a released data bus. The single-word and register-style modes run past one burst length, which distinguishes holding a word from stepping it and a burst end from none.

// File: rtl/sburst_rd_ctrl.sv
module sburst_rd_ctrl #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int LATW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          lat_n,
  input  logic [AW-1:0] addr_i,
  input  logic [LATW-1:0] lat_cfg,
  input  logic [1:0]    blen_cfg,
  input  logic [1:0]    mode_cfg,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          wait_o,
  output logic          wait_oe
);

  localparam logic [1:0] M_SINGLE = 2'd1;
  localparam logic [1:0] M_REG    = 2'd2;
  localparam logic [LATW-1:0] LAT_MIN = LATW'(2);

  logic            active, dvalid, ended;
  logic [AW-1:0]   base, off;
  logic [LATW-1:0] cnt, lat_q;
  logic [1:0]      blen_q, mode_q;
  logic [AW-1:0]   wrap_mask, cur_addr, lin_addr;

  wire cont  = (blen_q == 2'd3);
  wire hold  = (mode_q == M_SINGLE) || (mode_q == M_REG);
  wire last  = !cont && ((off & wrap_mask) == wrap_mask);
  wire [LATW-1:0] lat_eff = (lat_cfg < LAT_MIN) ? LAT_MIN : lat_cfg;

  always_comb begin
    case (blen_q)
      2'd0:    wrap_mask = AW'(3);
      2'd1:    wrap_mask = AW'(7);
      2'd2:    wrap_mask = AW'(15);
      default: wrap_mask = '1;
    endcase
  end

  assign lin_addr = base + off;
  assign cur_addr = hold ? base
                  : cont ? lin_addr
                  : (base & ~wrap_mask) | (lin_addr & wrap_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dvalid <= 1'b0;
      ended  <= 1'b0;
      base   <= '0;
      off    <= '0;
      cnt    <= '0;
      lat_q  <= LAT_MIN;
      blen_q <= '0;
      mode_q <= '0;
    end else if (ce_n) begin
      active <= 1'b0;
      dvalid <= 1'b0;
      ended  <= 1'b0;
    end else if (clk_en) begin
      if (!lat_n) begin
        active <= 1'b1;
        dvalid <= 1'b0;
        ended  <= 1'b0;
        base   <= addr_i;
        off    <= '0;
        cnt    <= '0;
        lat_q  <= lat_eff;
        blen_q <= blen_cfg;
        mode_q <= mode_cfg;
      end else if (active && !ended) begin
        if (!dvalid) begin
          if (cnt == lat_q - LATW'(1)) dvalid <= 1'b1;
          else                         cnt <= cnt + LATW'(1);
        end else if (mode_q == M_REG) begin
          if (last) begin
            dvalid <= 1'b0;
            ended  <= 1'b1;
          end else begin
            off <= off + AW'(1);
          end
        end else if (mode_q != M_SINGLE) begin
          off <= off + AW'(1);
        end
      end
    end
  end

  assign dq_o    = dvalid ? DW'({~cur_addr, cur_addr}) : '0;
  assign dq_oe   = !ce_n && !oe_n;
  assign wait_oe = !ce_n;
  assign wait_o  = !ce_n && !dvalid;

endmodule

// File: rtl/sburst_rd_ctrl_chk.sv
module sburst_rd_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          ce_n,
  input logic          oe_n,
  input logic          lat_n,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe,
  input logic          wait_o,
  input logic          wait_oe
);

  assert_capture_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ce_n && !lat_n) |=> (ce_n || wait_o));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !clk_en) |=> $stable(dq_o));

  assert_valid_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $fell(wait_o)) |-> $past(clk_en));

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!wait_oe && !dq_oe && !wait_o));

  assert_wait_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> (wait_oe && !dq_oe));

  assert_idle_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (dq_o == '0));

endmodule

bind sburst_rd_ctrl sburst_rd_ctrl_chk #(.DW(DW)) chk_i (.*);

// File: tb/sburst_rd_ctrl_test.sv
`timescale 1ns/1ps
module sburst_rd_ctrl_test;
  logic clk = 0, rst_n = 0, clk_en = 1, ce_n = 1, oe_n = 1, lat_n = 1;
  logic [7:0] addr_i = 0;
  logic [2:0] lat_cfg = 3;
  logic [1:0] blen_cfg = 0, mode_cfg = 0;
  logic [15:0] dq_o;
  logic dq_oe, wait_o, wait_oe;

  sburst_rd_ctrl uut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference
  bit m_act, m_val, m_end;
  int m_base, m_off, m_cnt, m_lat, m_blen, m_mode;

  function automatic int blen_words(int b);
    return b == 0 ? 4 : b == 1 ? 8 : b == 2 ? 16 : 0;
  endfunction

  function automatic int ref_addr();
    int n;
    if (m_mode == 1 || m_mode == 2) return m_base;
    n = blen_words(m_blen);
    if (n == 0) return (m_base + m_off) % 256;
    return (m_base / n) * n + ((m_base + m_off) % n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_val = 0; m_end = 0;
    end else if (ce_n) begin
      m_act = 0; m_val = 0; m_end = 0;
    end else if (clk_en) begin
      if (!lat_n) begin
        m_act = 1; m_val = 0; m_end = 0;
        m_base = addr_i; m_off = 0; m_cnt = 0;
        m_lat = (lat_cfg < 2) ? 2 : lat_cfg;
        m_blen = blen_cfg; m_mode = mode_cfg;
      end else if (m_act && !m_end) begin
        if (!m_val) begin
          m_cnt++;
          if (m_cnt == m_lat) m_val = 1;
        end else if (m_mode == 2) begin
          if (m_blen != 3 && m_off == blen_words(m_blen) - 1) begin
            m_val = 0; m_end = 1;
          end else m_off++;
        end else if (m_mode != 1) m_off++;
      end
    end
  end

  always @(negedge clk) begin
    logic [15:0] e_dq;
    logic e_w, e_woe, e_doe;
    int a;
    if (!done) begin
      a = ref_addr();
      e_dq  = m_val ? {~a[7:0], a[7:0]} : 16'h0;
      e_w   = !ce_n && !m_val;
      e_woe = !ce_n;
      e_doe = !ce_n && !oe_n;
      compared++;
      if (dq_o !== e_dq || wait_o !== e_w || wait_oe !== e_woe || dq_oe !== e_doe) begin
        mismatched++;
        $display("FAIL %s: dq=%h w=%b woe=%b doe=%b expected dq=%h w=%b woe=%b doe=%b",
                 tag, dq_o, wait_o, wait_oe, dq_oe, e_dq, e_w, e_woe, e_doe);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic start(int a, int lat, int bl, int md);
    ce_n = 0; oe_n = 0; clk_en = 1; lat_n = 0;
    addr_i = a[7:0]; lat_cfg = lat[2:0]; blen_cfg = bl[1:0]; mode_cfg = md[1:0];
    step(1);
    lat_n = 1;
  endtask

  task automatic finish_access();
    ce_n = 1; oe_n = 1; step(2);
  endtask

  task automatic chk_dq(string t, logic [15:0] exp);
    compared++;
    if (dq_o !== exp) begin
      mismatched++;
      $display("FAIL %s: dq=%h expected %h", t, dq_o, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1;
    tag = "R1"; step(3);

    tag = "R2_R4";
    start(8'h3E, 3, 0, 0);
    step(3); chk_dq("R2", 16'hC13E);
    step(1); chk_dq("R4", 16'hC03F);
    step(1); chk_dq("R4", 16'hC33C);
    step(6);
    finish_access();

    tag = "R3"; start(8'h10, 7, 1, 0); step(12); finish_access();
    tag = "R3"; start(8'h20, 0, 0, 0); step(6);  finish_access();
    tag = "R3"; start(8'h21, 2, 0, 0); step(6);  finish_access();
    tag = "R4"; start(8'h35, 4, 1, 0); step(14); finish_access();
    tag = "R4"; start(8'h4B, 2, 2, 3); step(22); finish_access();
    tag = "R5"; start(8'hFC, 2, 3, 0); step(10); finish_access();

    tag = "R6";
    start(8'h57, 5, 0, 0);
    step(2); clk_en = 0; oe_n = 1; step(4); oe_n = 0; clk_en = 1;
    step(4); clk_en = 0; oe_n = 1; step(3); oe_n = 0; clk_en = 1;
    step(1); clk_en = 0; oe_n = 1; step(2); oe_n = 0; clk_en = 1;
    step(6);
    finish_access();

    tag = "R7";
    start(8'h60, 2, 3, 0);
    step(3); oe_n = 1; step(3); oe_n = 0; step(2);
    ce_n = 1; step(2);
    ce_n = 0; step(3);
    finish_access();

    tag = "R8"; start(8'h77, 3, 0, 1); step(12); finish_access();
    tag = "R9"; start(8'h81, 2, 0, 2); step(10); finish_access();
    tag = "R9"; start(8'h92, 3, 1, 2); step(15); finish_access();
    tag = "R9"; start(8'hA3, 2, 3, 2); step(22); finish_access();
    tag = "R10"; start(8'hB4, 6, 2, 3); step(8); oe_n = 1; step(2); finish_access();

    summary();
  end
endmodule